// File: doc/BRIEF.md
# Four-Mode Buffered Serial Transmitter

This block sends bytes on a serial line in one of four framings. Code 0 is a synchronous shift mode: eight data bits go out on a dedicated data line while the transmit line carries a shift clock that the block generates itself. Code 1 is an asynchronous 10-bit frame. Codes 2 and 3 are asynchronous 11-bit frames that carry a ninth data bit. Codes 0 and 2 take their bit timing from fixed divisions of the block clock. Codes 1 and 3 count pulses on an external baud tick input, which comes from a timer overflow elsewhere in the chip.

A write presents a byte, a ninth bit and a mode code together. An accepted write lands in a one-entry holding register. The holding register hands its contents to the shift register as soon as the shifter is idle, or in the same cycle that the last bit of the current frame finishes. This lets consecutive frames run with no idle time between them. A transmit interrupt flag rises on each handover, so software knows it may write the next byte.

Top module: `serial_tx_multimode`

## Requirements
- R1: A write is accepted only when the holding register is empty. When the shifter is idle, the first bit of the frame appears on the line one clock after the edge that accepted the write.
- R2: Mode code 0 sends exactly 8 data bits on `sdata_o`, least significant bit first. Each bit lasts `SHIFT_DIV` (16) clocks.
- R3: In mode code 0, `txd_o` is the shift clock. It is low for the first half of each bit time, high for the second half, and high while idle.
- R4: Mode code 1 sends 10 bits on `txd_o`: a 0 start bit, data bits 0 to 7, then a 1 stop bit. Each bit lasts `TICKS_PER_BIT` (16) baud ticks.
- R5: Mode code 2 sends 11 bits on `txd_o`: a 0 start bit, data bits 0 to 7, the ninth bit, then a 1 stop bit. Each bit lasts `FIX9_DIV` (32) clocks.
- R6: Mode code 3 uses the same 11-bit frame as code 2. Each bit lasts 16 baud ticks.
- R7: A frame waiting in the holding register starts at the very edge where the current frame's last bit ends, with no idle gap. This holds even when the two frames use different modes.
- R8: `tx_irq_o` is 0 after reset. It sets on the cycle after a handover from the holding register to the shifter, and it clears on the cycle after an accepted write.
- R9: A write made while the holding register is full is dropped. Its byte is never sent, and `tx_irq_o` stays low until the next handover.
- R10: With no frame in progress, `txd_o` and `sdata_o` are both high. This is also the state after reset.
- R11: The mode code and the ninth bit are captured when the write is accepted. Later changes on `mode_i` or `wr_bit9_i` do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Framing code for the byte being written (0 to 3) |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to send |
| wr_bit9_i | input | 1 | Ninth data bit used by codes 2 and 3 |
| baud_tick_i | input | 1 | Timer overflow pulse that paces codes 1 and 3 |
| txd_o | output | 1 | Asynchronous line, or the shift clock in code 0 |
| sdata_o | output | 1 | Data line for code 0; high otherwise |
| tx_irq_o | output | 1 | Transmit interrupt flag: holding register freed |

## Verification
The hardest case to reach is a frame ending while the holding register is full and a third write is pending.

The stimulus writes one byte, then issues two more writes while that first frame is still shifting. The second write fills the holding register. The third write arrives against a full register and must be dropped.

Bits are sampled at positions measured in clocks or in baud ticks from the start of the frame. The second frame is checked at an offset of exactly one frame length, which shows that no gap appears. After both frames end, the line is watched long enough to confirm that the dropped byte never goes out. A separate sequence chains a code 2 frame straight into a code 0 frame, so the handover is also checked across a change of timebase.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        TXM_SHIFT  = 2'd0,
        TXM_ASYNC8 = 2'd1,
        TXM_FIX9   = 2'd2,
        TXM_VAR9   = 2'd3
    } tx_mode_e;

    // Framings paced by the external timer tick instead of the block clock.
    function automatic logic mode_uses_tick(tx_mode_e m);
        return (m == TXM_ASYNC8) || (m == TXM_VAR9);
    endfunction

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk
    import sertx_pkg::*;
#(
    parameter int SHIFT_DIV     = 16,
    parameter int FIX9_DIV      = 32,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart_i,
    input  logic     active_i,
    input  tx_mode_e mode_i,
    input  logic     baud_tick_i,
    output logic     bit_done_o,
    output logic     late_half_o
);

    localparam int MAXP_A = (SHIFT_DIV > FIX9_DIV) ? SHIFT_DIV : FIX9_DIV;
    localparam int MAXP   = (MAXP_A > TICKS_PER_BIT) ? MAXP_A : TICKS_PER_BIT;
    localparam int CW     = (MAXP > 2) ? $clog2(MAXP) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] last_cnt;
    logic          unit;

    always_comb begin
        unit = mode_uses_tick(mode_i) ? baud_tick_i : 1'b1;
        case (mode_i)
            TXM_SHIFT: last_cnt = CW'(SHIFT_DIV - 1);
            TXM_FIX9:  last_cnt = CW'(FIX9_DIV - 1);
            default:   last_cnt = CW'(TICKS_PER_BIT - 1);
        endcase
        bit_done_o  = active_i && unit && (st_q.cnt == last_cnt);
        late_half_o = st_q.cnt > (last_cnt >> 1);

        st_d = st_q;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (active_i && unit) begin
            st_d.cnt = bit_done_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 / R5: the position inside a bit never passes the last unit of the period
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (st_q.cnt <= last_cnt));

    // R4 / R6: without a tick, the timer-paced framings do not advance
    a_r4_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && mode_uses_tick(mode_i) && !baud_tick_i && !restart_i)
        |=> $stable(st_q.cnt));

endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf
    import sertx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          wr_bit9_i,
    input  tx_mode_e      wr_mode_i,
    input  logic          take_i,
    output logic          accept_o,
    output logic          full_o,
    output logic [DW-1:0] data_o,
    output logic          bit9_o,
    output tx_mode_e      mode_o
);

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
        logic          bit9;
        tx_mode_e      mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        accept_o = wr_en_i && !st_q.full;
        st_d     = st_q;
        if (take_i) begin
            st_d.full = 1'b0;
        end
        if (accept_o) begin
            st_d.full = 1'b1;
            st_d.data = wr_data_i;
            st_d.bit9 = wr_bit9_i;
            st_d.mode = wr_mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{full: 1'b0, data: '0, bit9: 1'b0, mode: TXM_SHIFT};
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;
    assign bit9_o = st_q.bit9;
    assign mode_o = st_q.mode;

    // R1: an accepted write occupies the holding register
    a_r1_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> st_q.full);

    // R9: a write against a full register leaves the stored byte untouched
    a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && wr_en_i) |=> $stable(st_q.data));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_full_i,
    input  logic [DW-1:0] hold_data_i,
    input  logic          hold_bit9_i,
    input  tx_mode_e      hold_mode_i,
    input  logic          bit_done_i,
    output logic          load_o,
    output logic          busy_o,
    output tx_mode_e      mode_o,
    output logic          line_o
);

    localparam int FW  = DW + 3;
    localparam int NBW = $clog2(FW + 1);

    typedef struct packed {
        logic           busy;
        tx_mode_e       mode;
        logic [FW-1:0]  sr;
        logic [NBW-1:0] idx;
        logic [NBW-1:0] last_idx;
    } st_t;

    st_t            st_d, st_q;
    logic           last_bit;
    logic [FW-1:0]  frame;
    logic [NBW-1:0] frame_last;

    always_comb begin
        case (hold_mode_i)
            TXM_SHIFT: begin
                frame      = {3'b111, hold_data_i};
                frame_last = NBW'(DW - 1);
            end
            TXM_ASYNC8: begin
                frame      = {2'b11, hold_data_i, 1'b0};
                frame_last = NBW'(DW + 1);
            end
            default: begin
                frame      = {1'b1, hold_bit9_i, hold_data_i, 1'b0};
                frame_last = NBW'(DW + 2);
            end
        endcase

        last_bit = st_q.busy && bit_done_i && (st_q.idx == st_q.last_idx);
        load_o   = hold_full_i && (!st_q.busy || last_bit);

        st_d = st_q;
        if (load_o) begin
            st_d.busy     = 1'b1;
            st_d.mode     = hold_mode_i;
            st_d.sr       = frame;
            st_d.idx      = '0;
            st_d.last_idx = frame_last;
        end else if (last_bit) begin
            st_d.busy = 1'b0;
            st_d.sr   = '1;
        end else if (st_q.busy && bit_done_i) begin
            st_d.sr  = {1'b1, st_q.sr[FW-1:1]};
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, mode: TXM_SHIFT, sr: '1, idx: '0, last_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign mode_o = st_q.mode;
    assign line_o = st_q.sr[0];

    // R7: a waiting frame takes over at the final bit edge, so the shifter never drops busy
    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && hold_full_i) |=> (st_q.busy && (st_q.idx == '0)));

    // R2 / R4 / R5: the bit index stays within the frame that was loaded
    a_r5_idx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.idx <= st_q.last_idx));

endmodule

// File: rtl/serial_tx_multimode.sv
module serial_tx_multimode
    import sertx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SHIFT_DIV     = 16,
    parameter int FIX9_DIV      = 32,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_bit9_i,
    input  logic              baud_tick_i,
    output logic              txd_o,
    output logic              sdata_o,
    output logic              tx_irq_o
);

    typedef struct packed {
        logic irq;
    } st_t;

    st_t               st_d, st_q;
    logic              accept, load, busy, line, bit_done, late_half;
    logic              hold_full, hold_bit9;
    logic [DATA_W-1:0] hold_data;
    tx_mode_e          hold_mode, cur_mode;

    sertx_holdbuf #(.DW(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .wr_bit9_i (wr_bit9_i),
        .wr_mode_i (tx_mode_e'(mode_i)),
        .take_i    (load),
        .accept_o  (accept),
        .full_o    (hold_full),
        .data_o    (hold_data),
        .bit9_o    (hold_bit9),
        .mode_o    (hold_mode)
    );

    sertx_shifter #(.DW(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .hold_bit9_i (hold_bit9),
        .hold_mode_i (hold_mode),
        .bit_done_i  (bit_done),
        .load_o      (load),
        .busy_o      (busy),
        .mode_o      (cur_mode),
        .line_o      (line)
    );

    sertx_bitclk #(
        .SHIFT_DIV     (SHIFT_DIV),
        .FIX9_DIV      (FIX9_DIV),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_bitclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (load),
        .active_i    (busy),
        .mode_i      (cur_mode),
        .baud_tick_i (baud_tick_i),
        .bit_done_o  (bit_done),
        .late_half_o (late_half)
    );

    always_comb begin
        st_d = st_q;
        if (load)        st_d.irq = 1'b1;
        else if (accept) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        txd_o   = 1'b1;
        sdata_o = 1'b1;
        if (busy) begin
            if (cur_mode == TXM_SHIFT) begin
                sdata_o = line;
                txd_o   = late_half;
            end else begin
                txd_o = line;
            end
        end
    end

    assign tx_irq_o = st_q.irq;

    // R8: a handover raises the flag
    a_r8_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_irq_o);

    // R8: an accepted write clears the flag
    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tx_irq_o);

    // R4 / R5 / R6: every asynchronous frame opens with a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && hold_mode != TXM_SHIFT) |=> !txd_o);

    // R3: in shift mode the clock is high on the last unit of each bit
    a_r3_clock_high_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_mode == TXM_SHIFT && bit_done) |-> txd_o);

endmodule

// File: tb/serial_tx_multimode_test.sv
module serial_tx_multimode_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       wr_bit9_i = 1'b0;
    logic       baud_tick_i = 1'b0;
    logic       txd_o, sdata_o, tx_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int clk_units = 0;
    int tick_units = 0;
    int tick_phase = 0;

    serial_tx_multimode uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .wr_bit9_i   (wr_bit9_i),
        .baud_tick_i (baud_tick_i),
        .txd_o       (txd_o),
        .sdata_o     (sdata_o),
        .tx_irq_o    (tx_irq_o)
    );

    always #4 clk = ~clk;

    // Time base seen by the design: clocks, and ticks sampled at each edge
    always @(posedge clk) begin
        clk_units  <= clk_units + 1;
        tick_units <= tick_units + (baud_tick_i ? 1 : 0);
    end

    // Tick on every third clock, changed away from the active edge
    always @(negedge clk) begin
        tick_phase  = (tick_phase == 2) ? 0 : tick_phase + 1;
        baud_tick_i = (tick_phase == 0);
    end

    // {mode, data, ninth bit}
    localparam logic [10:0] VEC [8] = '{
        {2'd0, 8'hA5, 1'b0},
        {2'd1, 8'h3C, 1'b0},
        {2'd2, 8'h96, 1'b1},
        {2'd3, 8'h41, 1'b0},
        {2'd0, 8'h01, 1'b1},
        {2'd1, 8'hFE, 1'b1},
        {2'd2, 8'h00, 1'b0},
        {2'd3, 8'hC7, 1'b1}
    };

    function automatic int period(int m);
        return (m == 2) ? 32 : 16;
    endfunction

    function automatic int nbits(int m);
        return (m == 0) ? 8 : ((m == 1) ? 10 : 11);
    endfunction

    function automatic int cur_units(int m);
        return (m == 1 || m == 3) ? tick_units : clk_units;
    endfunction

    function automatic logic exp_bit(int m, logic [7:0] d, logic b9, int i);
        if (m == 0) return d[i];
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9) return (m == 1) ? 1'b1 : b9;
        return 1'b1;
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, string what, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
        end
    endtask

    task automatic wait_units(int m, int target);
        while (cur_units(m) < target) @(negedge clk);
    endtask

    task automatic write_byte(int m, logic [7:0] d, logic b9);
        @(negedge clk);
        mode_i    = 2'(m);
        wr_data_i = d;
        wr_bit9_i = b9;
        wr_en_i   = 1'b1;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic check_frame(int m, logic [7:0] d, logic b9, int c0, string tag);
        int p;
        p = period(m);
        for (int i = 0; i < nbits(m); i++) begin
            if (m == 0) begin
                wait_units(m, c0 + i*p + p/4);
                check("R3", "shift clock low half", txd_o, 1'b0);
                wait_units(m, c0 + i*p + p/2);
                check(tag, "shift data bit", sdata_o, exp_bit(m, d, b9, i));
                wait_units(m, c0 + i*p + (3*p)/4);
                check("R3", "shift clock high half", txd_o, 1'b1);
            end else begin
                wait_units(m, c0 + i*p + p/2);
                check(tag, "async line bit", txd_o, exp_bit(m, d, b9, i));
                check("R10", "data line idle in async", sdata_o, 1'b1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=still running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int m, c0;
        logic [7:0] d;
        logic b9;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "reset txd", txd_o, 1'b1);
        check("R10", "reset sdata", sdata_o, 1'b1);
        check("R8", "reset irq", tx_irq_o, 1'b0);

        // Table walk: one frame per vector
        for (int v = 0; v < 8; v++) begin
            m  = int'(VEC[v][10:9]);
            d  = VEC[v][8:1];
            b9 = VEC[v][0];
            write_byte(m, d, b9);
            check("R8", "irq cleared by write", tx_irq_o, 1'b0);
            @(negedge clk);
            c0 = cur_units(m);
            check("R8", "irq set on handover", tx_irq_o, 1'b1);
            if (m == 0) check("R1", "first shift bit", sdata_o, d[0]);
            else        check("R1", "start bit", txd_o, 1'b0);
            check_frame(m, d, b9, c0, mode_tag(m));
            wait_units(m, c0 + nbits(m) * period(m));
            check("R10", "txd idle after frame", txd_o, 1'b1);
            check("R10", "sdata idle after frame", sdata_o, 1'b1);
        end

        // Back to back, plus a dropped third write
        write_byte(1, 8'h3C, 1'b0);
        @(negedge clk);
        c0 = cur_units(1);
        write_byte(1, 8'hC3, 1'b0);
        check("R8", "irq low after buffered write", tx_irq_o, 1'b0);
        write_byte(1, 8'hFF, 1'b1);
        check("R9", "irq low after dropped write", tx_irq_o, 1'b0);
        check_frame(1, 8'h3C, 1'b0, c0, "R7");
        check_frame(1, 8'hC3, 1'b0, c0 + 160, "R7");
        check("R8", "irq set on second handover", tx_irq_o, 1'b1);
        wait_units(1, c0 + 320);
        check("R10", "idle after pair", txd_o, 1'b1);
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            if (txd_o !== 1'b1) begin
                check("R9", "dropped byte never sent", txd_o, 1'b1);
                break;
            end
        end
        check("R9", "line still idle", txd_o, 1'b1);

        // Chained frames across a change of timebase
        write_byte(2, 8'h81, 1'b1);
        @(negedge clk);
        c0 = cur_units(2);
        write_byte(0, 8'h5A, 1'b0);
        check_frame(2, 8'h81, 1'b1, c0, "R7");
        check_frame(0, 8'h5A, 1'b0, c0 + 11*32, "R7");
        wait_units(0, c0 + 11*32 + 8*16);
        check("R10", "idle after chain", txd_o, 1'b1);

        // Mode and ninth bit are captured at the write
        write_byte(2, 8'h0F, 1'b1);
        mode_i    = 2'd1;
        wr_bit9_i = 1'b0;
        @(negedge clk);
        c0 = cur_units(2);
        check_frame(2, 8'h0F, 1'b1, c0, "R11");
        wait_units(2, c0 + 11*32);
        check("R11", "idle after captured frame", txd_o, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule